// File: doc/BRIEF.md
# Six-Step Inverter Gate Sequencer

This block produces the six gate-drive channels for a three-phase bridge inverter that uses six-step commutation. A prescaler with a division value that can be changed at run time turns the system clock into a single-cycle step tick. A synchronous modulo-6 state machine advances by one state on each tick. Each state selects a fixed 6-bit drive pattern, and that pattern is registered onto the gate outputs.

At every step exactly three channels are high and three are low. The six patterns follow a fixed commutation order. The current state number is also driven out, so that surrounding logic can align with the step. The block leaves out dead-time insertion and PWM within a step. Those belong to the power-stage logic around it.

Step state machine: the states are ST_0 through ST_5. On a tick the state makes the ADVANCE transition to the next state, and ST_5 makes the WRAP transition to ST_0. With no tick the state makes the HOLD transition and stays where it is. Any encoding outside 0..5 makes the RECOVER transition to ST_0.

Top module: `six_step_gate_seq`

## Requirements
- R1: `step_o` only takes the values 0 to 5. On each tick it advances by one, and after 5 it returns to 0.
- R2: The patterns on `gate_o` (bit 5 down to bit 0) are as follows: step 0 gives 6'b101010, step 1 gives 6'b001110, step 2 gives 6'b011100, step 3 gives 6'b010101, step 4 gives 6'b110001 and step 5 gives 6'b100011.
- R3: Outside reset, and from the second clock after reset is released, exactly three bits of `gate_o` are high.
- R4: While enabled, each step lasts exactly `div_i` clocks when `div_i` is 2 or more. When `div_i` is 0 or 1, the step advances on every clock.
- R5: `div_i` is captured only at the end of a step period, and also during reset. A change made partway through a step takes effect from the next step.
- R6: While `en_i` is low, `step_o`, `gate_o` and the prescaler count all hold their values. When `en_i` returns, the step still in progress needs its full remaining count of clocks.
- R7: While `rst_i` (synchronous, active high) is sampled high, `gate_o` is 0 and `step_o` is 0. On the first clock edge after release, `gate_o` is loaded with the pattern of the current step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low freezes the sequencer |
| div_i | input | DIV_W | Clocks per step |
| gate_o | output | 6 | Registered gate-drive channels |
| step_o | output | 3 | Current step number, 0..5 |

## Verification
A step tick and the change it causes on `step_o` and `gate_o` appear at the same clock edge. Both outputs come from registers loaded with the next state, so each step change shows up one edge after the cycle in which the prescaler count reaches the last count. The bench drives inputs and samples outputs at falling edges. It measures a step period as the number of falling edges between two observed changes of `step_o`, which equals the division value. After a reset is released, `gate_o` is due one edge later, and the bench samples it at the following falling edge. A new division value is expected one full period after it is applied partway through a step.

// File: rtl/six_step_gate_seq_pkg.sv
package six_step_gate_seq_pkg;

    localparam int NUM_CH    = 6;
    localparam int NUM_STEPS = 6;
    localparam int STEP_W    = 3;

    typedef enum logic [STEP_W-1:0] {
        ST_0 = 3'd0,
        ST_1 = 3'd1,
        ST_2 = 3'd2,
        ST_3 = 3'd3,
        ST_4 = 3'd4,
        ST_5 = 3'd5
    } step_state_e;

    // Drive pattern for a step, bit 5 down to bit 0.
    function automatic logic [NUM_CH-1:0] drive_pattern(input step_state_e st);
        logic [NUM_CH-1:0] pat;
        unique case (st)
            ST_0:    pat = 6'b101010;
            ST_1:    pat = 6'b001110;
            ST_2:    pat = 6'b011100;
            ST_3:    pat = 6'b010101;
            ST_4:    pat = 6'b110001;
            ST_5:    pat = 6'b100011;
            default: pat = '0;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/gs_prescaler.sv
module gs_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] count_q;
    logic [DIV_W-1:0] limit_q;
    logic [DIV_W-1:0] last_count;

    // A limit of 0 or 1 makes the last count 0, so a tick comes on every clock.
    always_comb begin
        last_count = (limit_q > ONE) ? (limit_q - ONE) : '0;
    end

    assign tick_o = en_i && (count_q >= last_count);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_q <= '0;
            limit_q <= div_i;
        end else if (tick_o) begin
            count_q <= '0;
            limit_q <= div_i;   // new value is taken only at the end of a period
        end else if (en_i) begin
            count_q <= count_q + ONE;
        end
    end

endmodule

// File: rtl/gs_step_fsm.sv
module gs_step_fsm
    import six_step_gate_seq_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        tick_i,
    output step_state_e state_o,
    output step_state_e state_next_o
);

    step_state_e state_q;
    step_state_e state_d;

    // Next-state logic: ADVANCE, WRAP, HOLD, RECOVER.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_0:    if (tick_i) state_d = ST_1;
            ST_1:    if (tick_i) state_d = ST_2;
            ST_2:    if (tick_i) state_d = ST_3;
            ST_3:    if (tick_i) state_d = ST_4;
            ST_4:    if (tick_i) state_d = ST_5;
            ST_5:    if (tick_i) state_d = ST_0;
            default: state_d = ST_0;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_0;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        state_o      = state_q;
        state_next_o = rst_i ? ST_0 : state_d;
    end

endmodule

// File: rtl/gs_drive_reg.sv
module gs_drive_reg
    import six_step_gate_seq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  step_state_e       state_next_i,
    output logic [NUM_CH-1:0] gate_o
);

    logic [NUM_CH-1:0] pattern_d;

    always_comb begin
        pattern_d = drive_pattern(state_next_i);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                gate_o[ch] <= 1'b0;
            end else begin
                gate_o[ch] <= pattern_d[ch];
            end
        end
    end

endmodule

// File: rtl/six_step_gate_seq.sv
module six_step_gate_seq
    import six_step_gate_seq_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [5:0]       gate_o,
    output logic [2:0]       step_o
);

    logic        step_tick;
    step_state_e state_cur;
    step_state_e state_nxt;

    gs_prescaler #(
        .DIV_W (DIV_W)
    ) i_prescaler (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .div_i  (div_i),
        .tick_o (step_tick)
    );

    gs_step_fsm i_step_fsm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .tick_i       (step_tick),
        .state_o      (state_cur),
        .state_next_o (state_nxt)
    );

    gs_drive_reg i_drive_reg (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .state_next_i (state_nxt),
        .gate_o       (gate_o)
    );

    assign step_o = state_cur;

endmodule

// File: rtl/six_step_gate_seq_chk.sv
module six_step_gate_seq_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       en_i,
    input logic [5:0] gate_o,
    input logic [2:0] step_o
);

    AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        step_o <= 3'd5) else $error("step out of range"); // R1

    AST_STEP_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(step_o) && $past(step_o) != 3'd5) |-> (step_o == $past(step_o) + 3'd1))
        else $error("step skipped"); // R1

    AST_STEP_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(step_o) && $past(step_o) == 3'd5) |-> (step_o == 3'd0))
        else $error("bad wrap"); // R1

    AST_THREE_ACTIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> ($countones(gate_o) == 3))
        else $error("active count wrong"); // R3

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(en_i) && !$past(rst_i) && !$past(rst_i, 2)) |-> ($stable(step_o) && $stable(gate_o)))
        else $error("moved while disabled"); // R6

    AST_MOVE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(step_o) |-> $past(en_i))
        else $error("step moved without enable"); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        $past(rst_i) |-> (gate_o == 6'd0 && step_o == 3'd0))
        else $error("reset values wrong"); // R7

endmodule

bind six_step_gate_seq six_step_gate_seq_chk i_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .gate_o (gate_o),
    .step_o (step_o)
);

// File: tb/test_six_step_gate_seq.sv
module test_six_step_gate_seq;

    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             en;
    logic [DIV_W-1:0] div;
    logic [5:0]       gate;
    logic [2:0]       step;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    six_step_gate_seq #(.DIV_W(DIV_W)) i_six_step_gate_seq (
        .clk_i  (clk),
        .rst_i  (rst),
        .en_i   (en),
        .div_i  (div),
        .gate_o (gate),
        .step_o (step)
    );

    function automatic logic [5:0] exp_pat(input int s);
        case (s)
            0: return 6'd42;
            1: return 6'd14;
            2: return 6'd28;
            3: return 6'd21;
            4: return 6'd49;
            5: return 6'd35;
            default: return 6'd0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Wait at falling edges until step changes; return the edge count.
    task automatic wait_change(output int n);
        logic [2:0] prev = step;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (step == prev && n < 1000);
    endtask

    task automatic do_reset(input int d);
        @(negedge clk);
        rst = 1'b1; en = 1'b0; div = DIV_W'(d);
        repeat (3) @(negedge clk);
        check(gate == 6'd0, "R7 gate in reset", gate, 0);
        check(step == 3'd0, "R7 step in reset", step, 0);
        rst = 1'b0;
        @(negedge clk);
        check(gate == exp_pat(0), "R7 pattern after release", gate, exp_pat(0));
        check(step == 3'd0, "R7 step after release", step, 0);
    endtask

    // Run n steps at the given period, checking order, pattern, count and timing.
    task automatic t_sequence(input int d, input int nsteps, input int per);
        int n;
        int expect_step;
        do_reset(d);
        en = 1'b1;
        expect_step = 0;
        for (int k = 0; k < nsteps; k++) begin
            wait_change(n);
            expect_step = (expect_step + 1) % 6;
            check(n == per, "R4 clocks per step", n, per);
            check(int'(step) == expect_step, "R1 step order and wrap", step, expect_step);
            check(gate == exp_pat(expect_step), "R2 pattern", gate, exp_pat(expect_step));
            check($countones(gate) == 3, "R3 three active", $countones(gate), 3);
        end
    endtask

    task automatic t_div_change();
        int n;
        t_sequence(4, 2, 4);
        div = DIV_W'(3);           // applied just after a step boundary
        @(negedge clk);
        n = 1;
        begin
            int m;
            wait_change(m);
            n += m;
        end
        check(n == 4, "R5 current step keeps old value", n, 4);
        wait_change(n);
        check(n == 3, "R5 new value from next step", n, 3);
        wait_change(n);
        check(n == 3, "R5 new value persists", n, 3);
    endtask

    task automatic t_enable_hold();
        int n;
        logic [2:0] s0;
        logic [5:0] g0;
        t_sequence(5, 1, 5);
        en = 1'b0;
        s0 = step; g0 = gate;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check(step == s0, "R6 step held", step, s0);
            check(gate == g0, "R6 gate held", gate, g0);
        end
        en = 1'b1;
        wait_change(n);
        check(n == 5, "R6 full period after resume", n, 5);
        check(int'(step) == (int'(s0) + 1) % 6, "R6 resumes in order", step, (int'(s0) + 1) % 6);
    endtask

    task automatic t_mid_reset();
        t_sequence(2, 3, 2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(gate == 6'd0, "R7 mid-run reset gate", gate, 0);
        check(step == 3'd0, "R7 mid-run reset step", step, 0);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; div = DIV_W'(4);
        repeat (2) @(negedge clk);
        t_sequence(4, 13, 4);     // R1 R2 R3 R4 over two full rotations
        t_sequence(0, 8, 1);      // R4 div of 0
        t_sequence(1, 8, 1);      // R4 div of 1
        t_sequence(7, 7, 7);      // R4 longer period
        t_div_change();           // R5
        t_enable_hold();          // R6
        t_mid_reset();            // R7
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

endmodule